// File: doc/BRIEF.md
# Power Mode State Machine

This block tracks the operating mode of a power-management device. It reads three supply-qualification flags (power-on-reset valid, system-low valid, system-high valid) and four request pulses (ON, OFF, WAKE, SLEEP). An upstream arbiter has already put the requests in order. From these inputs it keeps one of five modes. The two lowest modes, no-supply and backup, follow the supply flags alone. The three upper modes, off, active and sleep, change only when a legal request is made.

When a legal request arrives, the block sends a one-cycle start strobe and a transition code to an external sequencer. It then holds a busy flag until the sequencer returns a done pulse, and only then moves to the target mode. If the supply flags fall, the block drops at once to backup or no-supply and abandons any transition in progress. All outputs are registered.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, the mode output is no-supply, and busy and start are low. The mode codes are no-supply=0, backup=1, off=2, active=3 and sleep=4.
- R2: If the POR flag is low at a clock edge, the mode is no-supply after that edge. If the POR flag is high and the system-low flag is low, the mode is backup. In both cases busy goes low, so a transition in progress is abandoned.
- R3: In no-supply or backup, if both the POR and system-low flags are high at an edge, the mode becomes off after that edge, with no start strobe and with busy low.
- R4: Only five request/mode pairs are accepted, each with its code: ON in off gives 0 (to active), OFF in active gives 1 (to off), SLEEP in active gives 2 (to sleep), WAKE in sleep gives 3 (to active), and OFF in sleep gives 4 (to off). Any other request leaves start, busy and mode unchanged.
- R5: A request that would enter active (code 0 or 3) is accepted only if the system-high flag is high in the same cycle. Otherwise it is ignored.
- R6: After the edge that accepts a request, start is high for exactly one cycle and shows the code. Busy rises together with start, and the mode stays at the source mode.
- R7: While busy, all requests are ignored and the mode is held. After the edge that samples seq_done high, the mode equals the target and busy is low.
- R8: A seq_done pulse while not busy has no effect on the mode.
- R9: No start strobe is ever issued while in no-supply or backup. Requests made in those modes are ignored.
- R10: If OFF is asserted together with SLEEP in active, or together with WAKE in sleep, the OFF request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_ok | input | 1 | Supply is above the power-on-reset level |
| sys_lo_ok | input | 1 | Supply is above the system-low level |
| sys_hi_ok | input | 1 | Supply is above the system-high level |
| req_on | input | 1 | ON request pulse |
| req_off | input | 1 | OFF request pulse |
| req_wake | input | 1 | WAKE request pulse |
| req_sleep | input | 1 | SLEEP request pulse |
| seq_done | input | 1 | Sequencer finished the current transition |
| mode | output | 3 | Current mode code |
| seq_start | output | 1 | One-cycle transition start strobe |
| seq_code | output | 3 | Transition code, valid while seq_start is high |
| busy | output | 1 | A transition is awaiting seq_done |

## Verification
The assertions check the following on every cycle:
- a drop of a supply flag forces the mode down on the next cycle;
- start never appears without busy, or in a low-supply mode;
- the mode stays still while a transition is pending;
- a code that enters active was requested with the system-high flag present.

The bench scenarios cover what the assertions cannot. They test every request in every upper mode, with the high flag both set and cleared, and check the exact code and target mode against a model built from the legality table. They also cover abandoning a transition partway through, a stray done pulse, and simultaneous requests.

// File: rtl/pwr_mode_pkg.sv
`timescale 1ns/1ps
package pwr_mode_pkg;
  localparam int MODE_W = 3;
  localparam int CODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    PM_NOSUP  = 3'd0,
    PM_BACKUP = 3'd1,
    PM_OFF    = 3'd2,
    PM_ACTIVE = 3'd3,
    PM_SLEEP  = 3'd4
  } pm_mode_e;

  typedef enum logic [CODE_W-1:0] {
    XF_OFF2ACT = 3'd0,
    XF_ACT2OFF = 3'd1,
    XF_ACT2SLP = 3'd2,
    XF_SLP2ACT = 3'd3,
    XF_SLP2OFF = 3'd4
  } pm_xfer_e;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_OK   = 2'd2
  } pm_level_e;

  typedef struct packed {
    logic on;
    logic off;
    logic wake;
    logic sleep;
  } pm_req_t;
endpackage

// File: rtl/pwr_supply_level.sv
`timescale 1ns/1ps
module pwr_supply_level
  import pwr_mode_pkg::*;
(
  input  logic      por_ok,
  input  logic      sys_lo_ok,
  output pm_level_e level
);
  // The POR flag dominates; the system-low flag only matters above it.
  always_comb begin
    if (!por_ok)          level = LVL_NONE;
    else if (!sys_lo_ok)  level = LVL_LOW;
    else                  level = LVL_OK;
  end
endmodule

// File: rtl/pwr_req_decode.sv
`timescale 1ns/1ps
module pwr_req_decode
  import pwr_mode_pkg::*;
(
  input  pm_mode_e mode,
  input  pm_req_t  req,
  input  logic     hi_ok,
  output logic     accept,
  output pm_xfer_e code,
  output pm_mode_e target
);
  // Legality table; OFF is tested first so it wins over SLEEP/WAKE (R10).
  always_comb begin
    accept = 1'b0;
    code   = XF_OFF2ACT;
    target = mode;
    case (mode)
      PM_OFF: begin
        if (req.on && hi_ok) begin
          accept = 1'b1; code = XF_OFF2ACT; target = PM_ACTIVE;
        end
      end
      PM_ACTIVE: begin
        if (req.off) begin
          accept = 1'b1; code = XF_ACT2OFF; target = PM_OFF;
        end else if (req.sleep) begin
          accept = 1'b1; code = XF_ACT2SLP; target = PM_SLEEP;
        end
      end
      PM_SLEEP: begin
        if (req.off) begin
          accept = 1'b1; code = XF_SLP2OFF; target = PM_OFF;
        end else if (req.wake && hi_ok) begin
          accept = 1'b1; code = XF_SLP2ACT; target = PM_ACTIVE;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
`timescale 1ns/1ps
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pm_level_e level,
  input  logic      hi_ok,
  input  logic      accept,
  input  pm_xfer_e  code_in,
  input  pm_mode_e  target_in,
  input  logic      seq_done,
  output pm_mode_e  mode_q,
  output logic      start_q,
  output pm_xfer_e  code_q,
  output logic      busy_q
);
  pm_mode_e target_q;
  logic     low_mode;

  assign low_mode = (mode_q == PM_NOSUP) || (mode_q == PM_BACKUP);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= PM_NOSUP;
      target_q <= PM_NOSUP;
      code_q   <= XF_OFF2ACT;
      start_q  <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (level == LVL_NONE) begin
        mode_q <= PM_NOSUP;
        busy_q <= 1'b0;
      end else if (level == LVL_LOW) begin
        mode_q <= PM_BACKUP;
        busy_q <= 1'b0;
      end else if (low_mode) begin
        mode_q <= PM_OFF;
        busy_q <= 1'b0;
      end else if (busy_q) begin
        if (seq_done) begin
          mode_q <= target_q;
          busy_q <= 1'b0;
        end
      end else if (accept) begin
        start_q  <= 1'b1;
        code_q   <= code_in;
        target_q <= target_in;
        busy_q   <= 1'b1;
      end
    end
  end

  AST_START_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_q |-> busy_q); // R6
  AST_NO_SEQ_LOW_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    low_mode |-> (!start_q && !busy_q)); // R9
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !seq_done && level == LVL_OK) |=> $stable(mode_q)); // R7
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q); // R6
  AST_ACTIVE_NEEDS_HI: assert property (@(posedge clk) disable iff (rst)
    (start_q && (code_q == XF_OFF2ACT || code_q == XF_SLP2ACT)) |-> $past(hi_ok)); // R5
endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              por_ok,
  input  logic              sys_lo_ok,
  input  logic              sys_hi_ok,
  input  logic              req_on,
  input  logic              req_off,
  input  logic              req_wake,
  input  logic              req_sleep,
  input  logic              seq_done,
  output logic [MODE_W-1:0] mode,
  output logic              seq_start,
  output logic [CODE_W-1:0] seq_code,
  output logic              busy
);
  pm_level_e level;
  pm_req_t   req;
  pm_mode_e  mode_q;
  pm_xfer_e  dec_code;
  pm_mode_e  dec_target;
  pm_xfer_e  code_q;
  logic      dec_accept;

  assign req = '{on: req_on, off: req_off, wake: req_wake, sleep: req_sleep};

  pwr_supply_level u_level (
    .por_ok    (por_ok),
    .sys_lo_ok (sys_lo_ok),
    .level     (level)
  );

  pwr_req_decode u_decode (
    .mode   (mode_q),
    .req    (req),
    .hi_ok  (sys_hi_ok),
    .accept (dec_accept),
    .code   (dec_code),
    .target (dec_target)
  );

  pwr_mode_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .level     (level),
    .hi_ok     (sys_hi_ok),
    .accept    (dec_accept),
    .code_in   (dec_code),
    .target_in (dec_target),
    .seq_done  (seq_done),
    .mode_q    (mode_q),
    .start_q   (seq_start),
    .code_q    (code_q),
    .busy_q    (busy)
  );

  assign mode     = mode_q;
  assign seq_code = code_q;

  AST_POR_DROP: assert property (@(posedge clk) disable iff (rst)
    !por_ok |=> (mode == 3'd0 && !busy)); // R2
  AST_LO_DROP: assert property (@(posedge clk) disable iff (rst)
    (por_ok && !sys_lo_ok) |=> (mode == 3'd1 && !busy)); // R2
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> (seq_code <= 3'd4)); // R4
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_ok = 1'b0, sys_lo_ok = 1'b0, sys_hi_ok = 1'b0;
  logic req_on = 1'b0, req_off = 1'b0, req_wake = 1'b0, req_sleep = 1'b0;
  logic seq_done = 1'b0;
  logic [2:0] mode;
  logic seq_start;
  logic [2:0] seq_code;
  logic busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .rst(rst), .por_ok(por_ok), .sys_lo_ok(sys_lo_ok),
    .sys_hi_ok(sys_hi_ok), .req_on(req_on), .req_off(req_off),
    .req_wake(req_wake), .req_sleep(req_sleep), .seq_done(seq_done),
    .mode(mode), .seq_start(seq_start), .seq_code(seq_code), .busy(busy)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_req(input int r, input bit v);
    case (r)
      0: req_on = v;
      1: req_off = v;
      2: req_wake = v;
      default: req_sleep = v;
    endcase
  endtask

  // Reference legality table (R4, R5): r 0=ON 1=OFF 2=WAKE 3=SLEEP
  task automatic ref_xfer(input int m, input int r, input bit hi,
                          output bit ok, output int code, output int tgt);
    ok = 0; code = 0; tgt = m;
    if (m == 2 && r == 0 && hi)  begin ok = 1; code = 0; tgt = 3; end
    if (m == 3 && r == 1)        begin ok = 1; code = 1; tgt = 2; end
    if (m == 3 && r == 3)        begin ok = 1; code = 2; tgt = 4; end
    if (m == 4 && r == 2 && hi)  begin ok = 1; code = 3; tgt = 3; end
    if (m == 4 && r == 1)        begin ok = 1; code = 4; tgt = 2; end
  endtask

  task automatic do_reset();
    rst = 1'b1; por_ok = 1; sys_lo_ok = 1; sys_hi_ok = 1;
    req_on = 0; req_off = 0; req_wake = 0; req_sleep = 0; seq_done = 0;
    cyc();
    rst = 1'b0;
  endtask

  task automatic goto_mode(input int m);
    do_reset();
    cyc();                          // auto entry to off (R3)
    if (m >= 3) begin
      req_on = 1; cyc(); req_on = 0;
      seq_done = 1; cyc(); seq_done = 0;
    end
    if (m == 4) begin
      req_sleep = 1; cyc(); req_sleep = 0;
      seq_done = 1; cyc(); seq_done = 0;
    end
    chk("R7 setup mode", mode, m);
  endtask

  initial begin
    // R1 reset state
    rst = 1; por_ok = 1; sys_lo_ok = 1; sys_hi_ok = 1; req_on = 1;
    cyc(); cyc();
    chk("R1 mode in reset", mode, 0);
    chk("R1 busy in reset", busy, 0);
    chk("R1 start in reset", seq_start, 0);
    req_on = 0; por_ok = 0; sys_lo_ok = 0;
    rst = 0;
    cyc();
    chk("R1 mode after reset", mode, 0);

    // R9 requests ignored in no-supply and backup; R3 auto entry
    for (int r = 0; r < 4; r++) begin
      set_req(r, 1); cyc(); set_req(r, 0);
      chk("R9 no-supply start", seq_start, 0);
      chk("R9 no-supply mode", mode, 0);
    end
    por_ok = 1;
    cyc();
    chk("R2 backup mode", mode, 1);
    for (int r = 0; r < 4; r++) begin
      set_req(r, 1); cyc(); set_req(r, 0);
      chk("R9 backup start", seq_start, 0);
      chk("R9 backup mode", mode, 1);
    end
    sys_lo_ok = 1;
    cyc();
    chk("R3 auto off mode", mode, 2);
    chk("R3 auto off start", seq_start, 0);
    chk("R3 auto off busy", busy, 0);

    // R4 R5 R6 R7 sweep over source mode, request and high flag
    for (int m = 2; m <= 4; m++) begin
      for (int r = 0; r < 4; r++) begin
        for (int h = 0; h < 2; h++) begin
          bit ok; int code; int tgt;
          ref_xfer(m, r, h[0], ok, code, tgt);
          goto_mode(m);
          sys_hi_ok = h[0];
          set_req(r, 1); cyc(); set_req(r, 0);
          sys_hi_ok = 1;
          chk("R4 start", seq_start, ok);
          chk("R6 busy rise", busy, ok);
          chk("R6 mode held", mode, m);
          if (ok) begin
            chk("R4 code", seq_code, code);
            req_off = 1; req_on = 1; req_wake = 1; req_sleep = 1;
            cyc();
            req_off = 0; req_on = 0; req_wake = 0; req_sleep = 0;
            chk("R6 single pulse", seq_start, 0);
            chk("R7 busy held", busy, 1);
            chk("R7 mode held busy", mode, m);
            seq_done = 1; cyc(); seq_done = 0;
            chk("R7 target mode", mode, tgt);
            chk("R7 busy clear", busy, 0);
          end
        end
      end
    end

    // R2 abort by system-low drop, then R8 stray done
    goto_mode(2);
    req_on = 1; cyc(); req_on = 0;
    chk("R6 busy before abort", busy, 1);
    sys_lo_ok = 0; cyc();
    chk("R2 abort to backup", mode, 1);
    chk("R2 abort busy", busy, 0);
    sys_lo_ok = 1; cyc();
    chk("R3 back to off", mode, 2);
    seq_done = 1; cyc(); seq_done = 0;
    chk("R8 stray done mode", mode, 2);
    chk("R8 stray done start", seq_start, 0);

    // R2 POR drop from active and from sleep while busy
    goto_mode(3);
    por_ok = 0; cyc();
    chk("R2 por drop active", mode, 0);
    goto_mode(4);
    req_off = 1; cyc(); req_off = 0;
    por_ok = 0; sys_lo_ok = 0; cyc();
    chk("R2 por drop sleep busy", mode, 0);
    chk("R2 por drop busy", busy, 0);

    // R10 simultaneous requests
    goto_mode(3);
    req_off = 1; req_sleep = 1; cyc(); req_off = 0; req_sleep = 0;
    chk("R10 off over sleep", seq_code, 1);
    goto_mode(4);
    req_off = 1; req_wake = 1; cyc(); req_off = 0; req_wake = 0;
    chk("R10 off over wake", seq_code, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule